// File: doc/BRIEF.md
# Multiplexed Address/Data Phase Decoder

This block sits on the target side of a synchronous bus. The bus shares one 32-bit set of lines between address and data, and one 4-bit set of lines between the command and the byte enables. The block watches the active-low frame line and splits each transaction into an address phase and the data phases that follow it. In the address phase it latches the address and the command. In each data phase it turns the active-low byte enables into an active-high lane mask and flags null beats. It also checks the single even-parity line that covers all 36 shared lines. The parity for a phase arrives one clock after that phase.

Every output is registered, so each result appears one clock after the bus cycle that produced it. The block does not decode address ranges, does not insert wait states and does not take part in arbitration. A downstream target consumes the address strobe, the transaction type and the per-beat mask to carry out its own access.

Top module: `mux_phase_decoder`

## Requirements
- R1: A bus cycle with `bus_frame_n` low, whose previous cycle had `bus_frame_n` high, is an address phase. `addr_valid` is high for exactly the one clock after such a cycle.
- R2: On an address phase, `addr_q` takes the value of `bus_ad`. It holds that value until the next address phase.
- R3: On an address phase, `xact_type` decodes `bus_cbe_n` as follows: 4'b0110 gives 2'd1 (memory read), 4'b0111 gives 2'd2 (memory write), and any other code gives 2'd3 (unsupported). The value holds until the next address phase.
- R4: A bus cycle is a data beat when `bus_frame_n` was low in the previous cycle. This includes the cycle in which frame goes high, which is the last beat. `beat_valid` is high for the clock after each data beat. It is never high together with `addr_valid`, and it is always high in the clock after `addr_valid`.
- R5: For a data beat, `beat_mask[i]` is the inverse of `bus_cbe_n[i]`, so bit i selects byte lane i (bits 8i+7..8i of `bus_ad`). When `beat_valid` is low, `beat_mask` is 0.
- R6: `beat_null` is high only for a data beat whose enables are 4'b1111, which means no bytes move. Enables of 4'b0000 give a mask of 4'b1111 with `beat_null` low.
- R7: `bus_par` is sampled in the cycle after an address phase or a data beat. If the XOR of the 32 `bus_ad` bits, the 4 `bus_cbe_n` bits and `bus_par` is 1, `parity_err` is high for one clock, one clock after that phase's strobe. A wrong `bus_par` in the cycle after a cycle that was neither kind of phase raises nothing.
- R8: `rst_n` is active low. Asserting it clears `addr_q`, `xact_type`, the strobes, the mask and `parity_err` at once. Its release passes through a two-stage synchronizer, so decoding resumes on the third rising edge after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_frame_n | input | 1 | Active-low transaction frame |
| bus_ad | input | 32 | Shared address/data lines |
| bus_cbe_n | input | 4 | Command in the address phase, active-low byte enables in data phases |
| bus_par | input | 1 | Even parity for the previous phase |
| addr_valid | output | 1 | One-clock strobe marking a captured address phase |
| addr_q | output | 32 | Latched address |
| xact_type | output | 2 | 0 none, 1 memory read, 2 memory write, 3 unsupported |
| beat_valid | output | 1 | One-clock strobe per data beat |
| beat_mask | output | 4 | Active-high byte-lane mask of the beat |
| beat_null | output | 1 | Beat with no bytes enabled |
| parity_err | output | 1 | One-clock parity mismatch flag |

## Verification
The bound checker checks the following on every cycle:
- the address and type hold between address strobes;
- an address strobe is always followed by a beat strobe, and the two never overlap;
- the mask is empty outside beats and on null beats;
- every parity error follows a phase strobe.

Other behaviour shows only in the bench's scenarios, run against its cycle-by-cycle model:
- the correct command codes and lane order;
- the last beat counted on the cycle frame rises;
- parity on the address phase compared with the data phases;
- wrong parity ignored after idle cycles;
- back-to-back transactions;
- a reset in the middle of a burst.

// File: rtl/mpd_pkg.sv
package mpd_pkg;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic [1:0] {
    XT_NONE  = 2'd0,
    XT_READ  = 2'd1,
    XT_WRITE = 2'd2,
    XT_OTHER = 2'd3
  } xact_e;

endpackage

// File: rtl/mpd_rst_sync.sv
module mpd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) sync_q <= '0;
    else              sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mpd_phase_track.sv
module mpd_phase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_n,
  output logic addr_phase,
  output logic data_phase
);

  logic frame_act;
  logic act_q;
  logic act_d;

  assign frame_act = ~frame_n;

  always_comb begin
    act_d = frame_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act_d;
  end

  // address phase: frame newly active; data beat: frame was active last cycle
  assign addr_phase = frame_act & ~act_q;
  assign data_phase = act_q;

endmodule

// File: rtl/mpd_addr_cmd.sv
module mpd_addr_cmd
  import mpd_pkg::*;
#(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_phase,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe_n,
  output logic [AD_W-1:0]  addr_q,
  output logic             addr_valid,
  output xact_e            xact_q
);

  logic [AD_W-1:0] addr_d;
  xact_e           xact_d;
  xact_e           xact_dec;
  logic            av_d;

  always_comb begin
    if (cbe_n == CBE_W'(CMD_MEM_RD))      xact_dec = XT_READ;
    else if (cbe_n == CBE_W'(CMD_MEM_WR)) xact_dec = XT_WRITE;
    else                                  xact_dec = XT_OTHER;
  end

  always_comb begin
    addr_d = addr_q;
    xact_d = xact_q;
    av_d   = addr_phase;
    if (addr_phase) begin
      addr_d = ad;
      xact_d = xact_dec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q     <= '0;
      xact_q     <= XT_NONE;
      addr_valid <= 1'b0;
    end else begin
      addr_q     <= addr_d;
      xact_q     <= xact_d;
      addr_valid <= av_d;
    end
  end

endmodule

// File: rtl/mpd_beat_decode.sv
module mpd_beat_decode #(
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_phase,
  input  logic [CBE_W-1:0] cbe_n,
  output logic             beat_valid,
  output logic [CBE_W-1:0] beat_mask,
  output logic             beat_null
);

  logic [CBE_W-1:0] mask_d;
  logic             null_d;
  logic             valid_d;

  for (genvar g = 0; g < CBE_W; g++) begin : g_lane
    assign mask_d[g] = data_phase & ~cbe_n[g];
  end

  always_comb begin
    valid_d = data_phase;
    null_d  = data_phase & (&cbe_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      beat_valid <= 1'b0;
      beat_mask  <= '0;
      beat_null  <= 1'b0;
    end else begin
      beat_valid <= valid_d;
      beat_mask  <= mask_d;
      beat_null  <= null_d;
    end
  end

endmodule

// File: rtl/mpd_parity_chk.sv
module mpd_parity_chk #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase,
  input  logic [AD_W-1:0]  ad,
  input  logic [CBE_W-1:0] cbe_n,
  input  logic             par,
  output logic             parity_err
);

  logic calc_q;
  logic calc_d;
  logic pend_q;
  logic pend_d;
  logic err_d;

  always_comb begin
    calc_d = ^{ad, cbe_n};
    pend_d = phase;
    // even parity: lines plus parity bit must XOR to zero
    err_d  = pend_q & (calc_q ^ par);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calc_q     <= 1'b0;
      pend_q     <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      calc_q     <= calc_d;
      pend_q     <= pend_d;
      parity_err <= err_d;
    end
  end

endmodule

// File: rtl/mux_phase_decoder.sv
module mux_phase_decoder
  import mpd_pkg::*;
#(
  parameter  int AD_W        = 32,
  parameter  int SYNC_STAGES = 2,
  localparam int CBE_W       = AD_W / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_frame_n,
  input  logic [AD_W-1:0]  bus_ad,
  input  logic [CBE_W-1:0] bus_cbe_n,
  input  logic             bus_par,
  output logic             addr_valid,
  output logic [AD_W-1:0]  addr_q,
  output logic [1:0]       xact_type,
  output logic             beat_valid,
  output logic [CBE_W-1:0] beat_mask,
  output logic             beat_null,
  output logic             parity_err
);

  logic  rst_int_n;
  logic  addr_phase;
  logic  data_phase;
  xact_e xact_q;

  mpd_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_int_n)
  );

  mpd_phase_track u_track (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .frame_n    (bus_frame_n),
    .addr_phase (addr_phase),
    .data_phase (data_phase)
  );

  mpd_addr_cmd #(.AD_W(AD_W), .CBE_W(CBE_W)) u_addr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .addr_phase (addr_phase),
    .ad         (bus_ad),
    .cbe_n      (bus_cbe_n),
    .addr_q     (addr_q),
    .addr_valid (addr_valid),
    .xact_q     (xact_q)
  );

  assign xact_type = xact_q;

  mpd_beat_decode #(.CBE_W(CBE_W)) u_beat (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .data_phase (data_phase),
    .cbe_n      (bus_cbe_n),
    .beat_valid (beat_valid),
    .beat_mask  (beat_mask),
    .beat_null  (beat_null)
  );

  mpd_parity_chk #(.AD_W(AD_W), .CBE_W(CBE_W)) u_par (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .phase      (addr_phase | data_phase),
    .ad         (bus_ad),
    .cbe_n      (bus_cbe_n),
    .par        (bus_par),
    .parity_err (parity_err)
  );

endmodule

// File: rtl/mpd_checker.sv
module mpd_checker #(
  parameter int AD_W  = 32,
  parameter int CBE_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_valid,
  input logic [AD_W-1:0]  addr_q,
  input logic [1:0]       xact_type,
  input logic             beat_valid,
  input logic [CBE_W-1:0] beat_mask,
  input logic             beat_null,
  input logic             parity_err
);

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> $stable(addr_q)); // R2

  AST_TYPE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |-> $stable(xact_type)); // R3

  AST_BEAT_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> beat_valid); // R4

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_valid && beat_valid)); // R4

  AST_MASK_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_valid |-> (beat_mask == '0)); // R5

  AST_NULL_NO_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
    beat_null |-> (beat_valid && beat_mask == '0)); // R6

  AST_PERR_AFTER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    parity_err |-> $past(addr_valid || beat_valid)); // R7

endmodule

bind mux_phase_decoder mpd_checker #(.AD_W(AD_W), .CBE_W(CBE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr_valid (addr_valid),
  .addr_q     (addr_q),
  .xact_type  (xact_type),
  .beat_valid (beat_valid),
  .beat_mask  (beat_mask),
  .beat_null  (beat_null),
  .parity_err (parity_err)
);

// File: tb/test_mux_phase_decoder.sv
module test_mux_phase_decoder;

  logic        clk;
  logic        rst_n;
  logic        bus_frame_n;
  logic [31:0] bus_ad;
  logic [3:0]  bus_cbe_n;
  logic        bus_par;
  logic        addr_valid;
  logic [31:0] addr_q;
  logic [1:0]  xact_type;
  logic        beat_valid;
  logic [3:0]  beat_mask;
  logic        beat_null;
  logic        parity_err;

  int total = 0;
  int bad   = 0;
  int perr_seen = 0;
  bit finished = 0;

  mux_phase_decoder i_mux_phase_decoder (
    .clk(clk), .rst_n(rst_n), .bus_frame_n(bus_frame_n), .bus_ad(bus_ad),
    .bus_cbe_n(bus_cbe_n), .bus_par(bus_par), .addr_valid(addr_valid),
    .addr_q(addr_q), .xact_type(xact_type), .beat_valid(beat_valid),
    .beat_mask(beat_mask), .beat_null(beat_null), .parity_err(parity_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int          m_cnt;
  bit          m_prev;
  bit          m_pend;
  bit          m_calc;
  bit          e_av, e_bv, e_null, e_perr;
  logic [31:0] e_addr;
  int          e_type;
  logic [3:0]  e_mask;

  task automatic m_clear();
    m_prev = 0; m_pend = 0; m_calc = 0;
    e_av = 0; e_bv = 0; e_null = 0; e_perr = 0;
    e_addr = '0; e_type = 0; e_mask = '0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0;
      m_clear();
    end else if (m_cnt < 2) begin
      m_cnt++;
      m_clear();
    end else begin
      bit act, nav, nbv;
      act = !bus_frame_n;
      nav = act && !m_prev;
      nbv = m_prev;
      e_perr = m_pend && (m_calc != bus_par);
      m_pend = nav || nbv;
      m_calc = ^{bus_ad, bus_cbe_n};
      e_av = nav;
      if (nav) begin
        e_addr = bus_ad;
        if (bus_cbe_n == 4'b0110)      e_type = 1;
        else if (bus_cbe_n == 4'b0111) e_type = 2;
        else                           e_type = 3;
      end
      e_bv   = nbv;
      e_mask = nbv ? ~bus_cbe_n : 4'b0;
      e_null = nbv && (bus_cbe_n == 4'b1111);
      m_prev = act;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    if (!finished) begin
      chk("R1", "addr_valid", 32'(addr_valid), 32'(e_av));
      chk("R2", "addr_q", addr_q, e_addr);
      chk("R3", "xact_type", 32'(xact_type), 32'(e_type));
      chk("R4", "beat_valid", 32'(beat_valid), 32'(e_bv));
      chk("R5", "beat_mask", 32'(beat_mask), 32'(e_mask));
      chk("R6", "beat_null", 32'(beat_null), 32'(e_null));
      chk("R7", "parity_err", 32'(parity_err), 32'(e_perr));
      if (parity_err === 1'b1) perr_seen++;
    end
  end

  // ---------------- stimulus ----------------
  logic [31:0] prev_ad  = '0;
  logic [3:0]  prev_cbe = '0;

  // drive one bus cycle; bad_par corrupts the parity of the previous cycle
  task automatic cyc(input bit act, input logic [31:0] ad, input logic [3:0] cbe, input bit bad_par);
    @(negedge clk);
    #1;
    bus_par     = (^{prev_ad, prev_cbe}) ^ bad_par;
    bus_frame_n = !act;
    bus_ad      = ad;
    bus_cbe_n   = cbe;
    prev_ad     = ad;
    prev_cbe    = cbe;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 32'h0, 4'hF, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int perr_base;
    rst_n = 0; bus_frame_n = 1; bus_ad = '0; bus_cbe_n = 4'hF; bus_par = 0;
    repeat (3) @(negedge clk);
    // R8 reset state at the ports
    chk("R8", "reset addr_q", addr_q, 32'h0);
    chk("R8", "reset xact_type", 32'(xact_type), 32'd0);
    chk("R8", "reset strobes", 32'({addr_valid, beat_valid, parity_err}), 32'd0);
    rst_n = 1;
    idle(4);

    // R3 memory read, single beat, all bytes (R6 0000 case)
    cyc(1, 32'h1000_0040, 4'b0110, 0);
    cyc(0, 32'hDEAD_BEEF, 4'b0000, 0);
    idle(2);
    chk("R3", "read type held", 32'(xact_type), 32'd1);
    chk("R2", "read addr held", addr_q, 32'h1000_0040);

    // R4/R5/R6 memory write burst with mixed enables, last beat on frame rise
    cyc(1, 32'h2000_0100, 4'b0111, 0);
    cyc(1, 32'h1111_1111, 4'b0101, 0);
    cyc(1, 32'h2222_2222, 4'b1111, 0);
    cyc(1, 32'h3333_3333, 4'b1110, 0);
    cyc(0, 32'h4444_4444, 4'b0111, 0);
    idle(2);
    chk("R3", "write type held", 32'(xact_type), 32'd2);

    // R3 unsupported command, then back-to-back transaction after one beat
    cyc(1, 32'h3000_0000, 4'b0010, 0);
    cyc(0, 32'h0000_0001, 4'b0011, 0);
    cyc(1, 32'h3000_0010, 4'b0110, 0);
    cyc(0, 32'h0000_0002, 4'b1100, 0);
    idle(2);

    // R7 parity error on address phase and on a data beat
    perr_base = perr_seen;
    cyc(1, 32'h4000_0000, 4'b0111, 0);
    cyc(1, 32'hA5A5_A5A5, 4'b0000, 1);
    cyc(1, 32'h5A5A_5A5A, 4'b0011, 0);
    cyc(0, 32'h0F0F_0F0F, 4'b1000, 1);
    cyc(0, 32'h0, 4'hF, 0);
    idle(3);
    chk("R7", "errors raised for corrupted phases", 32'(perr_seen - perr_base), 32'd2);

    // R7 corrupted parity after idle cycles is ignored
    perr_base = perr_seen;
    cyc(0, 32'hFFFF_0000, 4'h3, 1);
    cyc(0, 32'h0, 4'hF, 1);
    cyc(0, 32'h0, 4'hF, 1);
    idle(3);
    chk("R7", "no error after idle", 32'(perr_seen - perr_base), 32'd0);

    // R8 reset in the middle of a burst
    cyc(1, 32'h6000_0000, 4'b0110, 0);
    cyc(1, 32'h1, 4'b0000, 0);
    #2 rst_n = 0;
    #1 chk("R8", "async clear addr_q", addr_q, 32'h0);
    chk("R8", "async clear strobes", 32'({addr_valid, beat_valid, beat_mask}), 32'd0);
    cyc(1, 32'h2, 4'b0000, 0);
    cyc(1, 32'h3, 4'b0000, 0);
    @(negedge clk); rst_n = 1;
    cyc(1, 32'h7000_0000, 4'b0111, 0);
    cyc(1, 32'h5, 4'b0110, 0);
    cyc(1, 32'h6, 4'b1001, 0);
    cyc(0, 32'h7, 4'b0000, 0);
    idle(3);

    // mixed traffic against the model
    for (int i = 0; i < 2000; i++) begin
      cyc(($urandom % 10) < 7, $urandom, 4'($urandom), ($urandom % 10) == 0);
    end
    idle(4);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule